// File: doc/BRIEF.md
# Programmable Tap-Select Timer/Divider

A synchronous timer built on a 16-stage binary counter. A 2-bit stage select picks one counter stage as the output tap. That choice sets how many count strobes make up one timing interval.

The mode input sets how the tap is used:
- **Recycle mode:** the output follows the tap, so it is a square wave at the strobe rate divided by 2^N.
- **Single-transition mode:** the output changes state once, when the tap first goes high after a timer reset. It then holds that level, which makes the block a one-shot.

A polarity input sets the output level right after a reset. It also inverts the direction of every transition.

Two asynchronous reset sources are each passed through a two-flop synchroniser:
- a master reset;
- a power-on reset, which can be disabled.

While either source is active, the counter is held at zero and does not count. With the power-on source disabled, the timer stays unarmed after a system reset until a master reset pulse has come and gone. A master reset during an interval restarts that interval, so the one-shot can be retriggered.

Top module: `tap_timer`

## Requirements
- R1: The counter advances by exactly one on each clock edge where `cnt_en` is 1 and the timer is armed and not in reset. It holds its value when `cnt_en` is 0.
- R2: The stage select maps to a tap as follows. Code 2'b10 picks stage 8 (counter bit 7). Code 2'b01 picks stage 10 (bit 9). Code 2'b00 picks stage 13 (bit 12). Code 2'b11 picks stage 16 (bit 15).
- R3: With `mode`=1 (recycle), `tmr_out` toggles after every 2^(N-1) strobes, giving a full period of 2^N strobes.
- R4: With `mode`=0 (single transition), `tmr_out` changes level after exactly 2^(N-1) strobes following a timer reset. It keeps that level through any number of further strobes.
- R5: After a timer reset, `tmr_out` equals `pol_hi`. With `pol_hi`=1, every transition goes high-to-low instead of low-to-high.
- R6: While `mrst_in` is high (after synchronisation), the counter and the one-shot latch are cleared and strobes are ignored. Counting resumes after release.
- R7: With `auto_off`=0, a `por_in` pulse acts as a timer reset and arms the timer. With `auto_off`=1, `por_in` has no effect. After system reset, no strobe is counted until a master or enabled power-on reset pulse has been seen.
- R8: A master reset in the middle of a single-transition interval restarts the full interval of 2^(N-1) strobes.
- R9: Switching `mode` to 1 releases the one-shot latch, and the output then follows the tap. Changing `stage_sel` takes effect on the next clock without clearing the counter.
- R10: While `rst` is high, `tmr_out` is 0, the counter is cleared and the timer becomes unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_en | input | 1 | Count strobe; one count per clock while high |
| mrst_in | input | 1 | Asynchronous master reset, active high |
| por_in | input | 1 | Asynchronous power-on reset pulse, active high |
| auto_off | input | 1 | 1 disables the power-on reset source |
| stage_sel | input | 2 | Output stage select code |
| mode | input | 1 | 0 single transition, 1 recycle |
| pol_hi | input | 1 | Output level after a timer reset |
| tmr_out | output | 1 | Registered timer output |

## Verification
The hardest conditions to reach from the ports are:
- the unarmed state with the power-on source disabled;
- a one-shot latch that survives the tap going low again;
- a retrigger that lands part-way through an interval.

To reach them, the bench drives exact strobe counts with `cnt_en` gated per cycle. It checks the output one strobe before each expected edge and at the edge itself. It drives more than 256 extra strobes after a stage-8 latch, so that the tap wraps back to 0 while the output must stay put. It also changes the stage select with a known counter value, so that a counter cleared by the change would produce a visibly different output.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_STG_00 = 13;
    localparam int unsigned DEF_STG_01 = 10;
    localparam int unsigned DEF_STG_10 = 8;
    localparam int unsigned DEF_STG_11 = 16;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_RECYCLE = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic clr;   // timer reset active: clear count and latch
        logic adv;   // advance the counter this cycle
    } cnt_cmd_t;

endpackage

// File: rtl/tap_timer_sync.sv
module tap_timer_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/tap_timer_rstctl.sv
module tap_timer_rstctl
    import tap_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mrst_s,
    input  logic     por_s,
    input  logic     auto_off,
    input  logic     cnt_en,
    output cnt_cmd_t cmd,
    output logic     armed
);
    logic clr_now;

    assign clr_now = mrst_s | (por_s & ~auto_off);

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (clr_now)
            armed <= 1'b1;
    end

    always_comb begin
        cmd.clr = clr_now;
        cmd.adv = cnt_en & armed & ~clr_now;
    end
endmodule

// File: rtl/tap_timer_counter.sv
module tap_timer_counter
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clr)
            cnt_q <= '0;
        else if (cmd.adv)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tap_timer_outctl.sv
module tap_timer_outctl
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned STG_00 = DEF_STG_00,
    parameter int unsigned STG_01 = DEF_STG_01,
    parameter int unsigned STG_10 = DEF_STG_10,
    parameter int unsigned STG_11 = DEF_STG_11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [1:0]       stage_sel,
    input  tmr_mode_e        mode,
    input  logic             pol_hi,
    output logic             done_q,
    output logic             out_q
);
    logic tap;
    logic shot;

    // stage N is counter bit N-1
    always_comb begin
        unique case (stage_sel)
            2'b00:   tap = cnt_q[STG_00-1];
            2'b01:   tap = cnt_q[STG_01-1];
            2'b10:   tap = cnt_q[STG_10-1];
            default: tap = cnt_q[STG_11-1];
        endcase
        shot = done_q | tap;
    end

    always_ff @(posedge clk) begin
        if (rst || clr || mode == MODE_RECYCLE)
            done_q <= 1'b0;
        else
            done_q <= shot;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else
            out_q <= pol_hi ^ ((mode == MODE_RECYCLE) ? tap : shot);
    end
endmodule

// File: rtl/tap_timer.sv
module tap_timer
    import tap_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned STG_00 = DEF_STG_00,
    parameter int unsigned STG_01 = DEF_STG_01,
    parameter int unsigned STG_10 = DEF_STG_10,
    parameter int unsigned STG_11 = DEF_STG_11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    input  logic       mrst_in,
    input  logic       por_in,
    input  logic       auto_off,
    input  logic [1:0] stage_sel,
    input  logic       mode,
    input  logic       pol_hi,
    output logic       tmr_out
);
    localparam int unsigned N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_raw;
    logic [N_ASYNC-1:0] async_s;
    cnt_cmd_t           cmd;
    logic               armed;
    logic               rst_act;
    logic [CNT_W-1:0]   cnt_q;
    logic               done_q;

    assign async_raw = {por_in, mrst_in};
    assign rst_act   = cmd.clr;

    tap_timer_sync #(.W(N_ASYNC)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (async_raw),
        .q_sync  (async_s)
    );

    tap_timer_rstctl u_rstctl (
        .clk      (clk),
        .rst      (rst),
        .mrst_s   (async_s[0]),
        .por_s    (async_s[1]),
        .auto_off (auto_off),
        .cnt_en   (cnt_en),
        .cmd      (cmd),
        .armed    (armed)
    );

    tap_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .cnt_q (cnt_q)
    );

    tap_timer_outctl #(
        .CNT_W (CNT_W),
        .STG_00(STG_00),
        .STG_01(STG_01),
        .STG_10(STG_10),
        .STG_11(STG_11)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .clr       (cmd.clr),
        .cnt_q     (cnt_q),
        .stage_sel (stage_sel),
        .mode      (tmr_mode_e'(mode)),
        .pol_hi    (pol_hi),
        .done_q    (done_q),
        .out_q     (tmr_out)
    );
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             mode,
    input logic             rst_act,
    input logic             armed,
    input logic             done_q,
    input logic [CNT_W-1:0] cnt_q
);
    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rst_act |=> cnt_q == '0);

    // R1
    adv_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && armed && !rst_act) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R1
    hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !rst_act) |=> $stable(cnt_q));

    // R4
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !mode && !rst_act) |=> done_q);

    // R7
    unarmed_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> cnt_q == '0);
endmodule

bind tap_timer tap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .mode    (mode),
    .rst_act (rst_act),
    .armed   (armed),
    .done_q  (done_q),
    .cnt_q   (cnt_q)
);

// File: tb/sim_tap_timer.sv
module sim_tap_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       mrst_in = 1'b0;
    logic       por_in = 1'b0;
    logic       auto_off = 1'b1;
    logic [1:0] stage_sel = 2'b10;
    logic       mode = 1'b1;
    logic       pol_hi = 1'b0;
    logic       tmr_out;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tap_timer u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .mrst_in(mrst_in),
        .por_in(por_in), .auto_off(auto_off), .stage_sel(stage_sel),
        .mode(mode), .pol_hi(pol_hi), .tmr_out(tmr_out)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (tmr_out !== exp) begin
            n_bad++;
            $display("FAIL %s: tmr_out=%b expected %b", req, tmr_out, exp);
        end
    endtask

    task automatic strobe(input int n);
        @(negedge clk) cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_mrst();
        @(negedge clk) mrst_in = 1'b1;
        repeat (4) @(negedge clk);
        mrst_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk) por_in = 1'b1;
        repeat (4) @(negedge clk);
        por_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'b00:   return 4096;
            2'b01:   return 512;
            2'b10:   return 128;
            default: return 32768;
        endcase
    endfunction

    // R10 and R7: system reset state, unarmed timer, power-on source gating
    task automatic t_power_up();
        repeat (3) @(negedge clk);
        chk("R10 output low in reset", 1'b0);
        rst = 1'b0;
        stage_sel = 2'b10; mode = 1'b1; pol_hi = 1'b0; auto_off = 1'b1;
        strobe(200);
        chk("R7 unarmed ignores strobes", 1'b0);
        do_por();
        strobe(200);
        chk("R7 por ignored with auto_off=1", 1'b0);
        auto_off = 1'b0;
        do_por();
        strobe(127);
        chk("R7 por arms, 127 strobes", 1'b0);
        strobe(1);
        chk("R7 por arms, 128 strobes", 1'b1);
        auto_off = 1'b1;
    endtask

    // R4 R5 R2: one-shot for a code and polarity
    task automatic t_oneshot(input logic [1:0] s, input logic p);
        int h = half_of(s);
        stage_sel = s; pol_hi = p; mode = 1'b0;
        do_mrst();
        chk("R5 initial level", p);
        strobe(h - 1);
        chk("R4 before transition", p);
        strobe(1);
        chk("R2 R4 transition point", ~p);
        strobe(300);
        chk("R4 level held", ~p);
    endtask

    // R3 R2: recycle period for a code and polarity
    task automatic t_recycle(input logic [1:0] s, input logic p);
        int h = half_of(s);
        stage_sel = s; pol_hi = p; mode = 1'b1;
        do_mrst();
        chk("R5 recycle initial", p);
        strobe(h - 1);
        chk("R3 first half", p);
        strobe(1);
        chk("R3 first edge", ~p);
        strobe(h - 1);
        chk("R3 second half", ~p);
        strobe(1);
        chk("R3 full period", p);
    endtask

    // R6: strobes during master reset are ignored
    task automatic t_hold_reset();
        stage_sel = 2'b10; pol_hi = 1'b0; mode = 1'b1;
        @(negedge clk) mrst_in = 1'b1;
        repeat (4) @(negedge clk);
        strobe(200);
        chk("R6 no count during reset", 1'b0);
        mrst_in = 1'b0;
        repeat (4) @(negedge clk);
        strobe(127);
        chk("R6 restart from zero", 1'b0);
        strobe(1);
        chk("R6 counts after release", 1'b1);
    endtask

    // R8: retrigger in mid-interval
    task automatic t_retrigger();
        stage_sel = 2'b10; pol_hi = 1'b0; mode = 1'b0;
        do_mrst();
        strobe(100);
        do_mrst();
        strobe(100);
        chk("R8 interval restarted", 1'b0);
        strobe(28);
        chk("R8 fires after full interval", 1'b1);
    endtask

    // R9: mode release and select change without clearing
    task automatic t_switch();
        stage_sel = 2'b10; pol_hi = 1'b0; mode = 1'b0;
        do_mrst();
        strobe(256);
        chk("R9 latched at count 256", 1'b1);
        @(negedge clk) mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 recycle follows tap bit7 of 256", 1'b0);
        @(negedge clk) stage_sel = 2'b01;
        strobe(256);
        chk("R9 select kept count 512 bit9", 1'b1);
        @(negedge clk) stage_sel = 2'b10;
        repeat (2) @(negedge clk);
        chk("R9 select back bit7 of 512", 1'b0);
    endtask

    initial begin
        t_power_up();
        t_hold_reset();
        t_retrigger();
        t_switch();
        for (int i = 0; i < 4; i++) begin
            t_oneshot(2'(i), 1'b0);
            t_oneshot(2'(i), 1'b1);
        end
        for (int i = 0; i < 4; i++)
            t_recycle(2'(i), 1'b0);
        t_recycle(2'b10, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule